// File: doc/BRIEF.md
# Page Permission Remap Unit

This block turns the permission bits of a page-table entry into effective read, write and execute rights. The two access-permission bits and the two execute-never bits are joined into a 4-bit index. That index picks one 4-bit field out of a 64-bit permission register, and the field gives the rights. Two permission registers are held, one for user level and one for kernel level, so the two levels can grant different rights for the same entry. Each field carries two sub-fields: a guarded-mode code in its upper half and a normal-mode code in its lower half. The lookup port selects the level and the mode.

A configuration register holds an enable bit and three sticky lock bits. While the enable bit is clear, the block falls back to a conventional decode of the entry bits, and guarded mode gets no rights. Software loads the registers through a single plain register-write port. The lookup is purely combinational and has no handshake: the rights follow the lookup inputs in the same cycle. Because there is no streaming data path, there is no valid/ready interface and no back-pressure.

Top module: `ppr_remap_unit`

## Requirements
- R1: After reset, the enable bit, all lock bits and both permission registers are zero, so lookups use the fallback decode.
- R2: The lookup index is {ap[1], ap[0], uxn, pxn}, with ap[1] as the MSB. Index i selects bits [4i+3:4i] of the user register when lvl_kernel is 0, and of the kernel register when lvl_kernel is 1.
- R3: A 2-bit code decodes as 00 = no rights, 01 = read and execute, 10 = read only, 11 = read and write. Guarded mode decodes field bits [3:2]; normal mode decodes field bits [1:0].
- R4: Field value 4'b0111 gives no rights in normal mode and read and execute in guarded mode.
- R5: Field value 4'b1001 gives execute only in normal mode and read only in guarded mode.
- R6: A write with wr_en set goes to the configuration register when wr_sel is 0, to the user register when it is 1, and to the kernel register when it is 2. wr_sel 3 writes nothing. A write applies to lookups from the next cycle on.
- R7: Configuration bit 1 locks the configuration register; once it is set, all later writes to that register are ignored.
- R8: Configuration bit 4 locks the user register and bit 5 locks the kernel register. A locked register ignores writes, while the other register stays writable.
- R9: Lock bits can only be set. Writing 0 to a lock bit that is already set leaves it set until reset.
- R10: Configuration bit 0 enables the remap. While it is clear, normal mode decodes conventionally. At kernel level: read = 1, write = !ap[1], execute = !pxn. At user level: read = ap[0], write = ap[0] & !ap[1], execute = ap[0] & !uxn.
- R11: While the enable bit is clear, guarded mode gets no rights at either level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 configuration, 1 user, 2 kernel, 3 none |
| wr_data | input | 64 | Write data |
| lvl_kernel | input | 1 | Lookup level: 0 user, 1 kernel |
| mode_guarded | input | 1 | Lookup mode: 0 normal, 1 guarded |
| ap | input | 2 | Access-permission bits of the entry |
| uxn | input | 1 | User execute-never bit of the entry |
| pxn | input | 1 | Privileged execute-never bit of the entry |
| can_read | output | 1 | Read permitted |
| can_write | output | 1 | Write permitted |
| can_exec | output | 1 | Execute permitted |

## Verification
A corrupted permission field shows up at the ports only when a lookup uses that field's index at that level. For this reason the bench sweeps every index, both levels and both modes after each register load, using rotated patterns so that each register holds all sixteen field values across the sweep. A wrong enable or lock state shows up in the first lookup after the offending write. A lost enable bit returns the fallback rights. A lock that failed to hold lets a later write change the rights, and this is visible one cycle after that write.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  localparam int IDX_W   = 4;
  localparam int FIELD_W = 4;
  localparam int CODE_W  = 2;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_USER = 2'd1,
    SEL_KERN = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  function automatic rights_t code_to_rights(input logic [CODE_W-1:0] code);
    rights_t r;
    case (code)
      2'b01:   r = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
      2'b10:   r = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
      2'b11:   r = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
      default: r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ppr_cfg_reg.sv
module ppr_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic d_enable,
  input  logic d_lock_cfg,
  input  logic d_lock_user,
  input  logic d_lock_kern,
  output logic enable_q,
  output logic lock_cfg_q,
  output logic lock_user_q,
  output logic lock_kern_q
);

  logic accept;
  assign accept = wr_hit && !lock_cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q    <= 1'b0;
      lock_cfg_q  <= 1'b0;
      lock_user_q <= 1'b0;
      lock_kern_q <= 1'b0;
    end else if (accept) begin
      enable_q    <= d_enable;
      lock_cfg_q  <= lock_cfg_q  | d_lock_cfg;
      lock_user_q <= lock_user_q | d_lock_user;
      lock_kern_q <= lock_kern_q | d_lock_kern;
    end
  end

  // R7: frozen configuration
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cfg_q |=> $stable({enable_q, lock_user_q, lock_kern_q}));

  // R9: locks only ever set
  p_lock_user_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_user_q |=> lock_user_q);
  p_lock_kern_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_kern_q |=> lock_kern_q);
  p_lock_cfg_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cfg_q |=> lock_cfg_q);

endmodule

// File: rtl/ppr_perm_bank.sv
module ppr_perm_bank #(
  parameter int LEVELS = 2,
  parameter int PERM_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LEVELS-1:0]             wr_hit,
  input  logic [PERM_W-1:0]             wr_data,
  input  logic [LEVELS-1:0]             lock,
  output logic [LEVELS-1:0][PERM_W-1:0] perm_q
);

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        perm_q[g] <= '0;
      end else if (wr_hit[g] && !lock[g]) begin
        perm_q[g] <= wr_data;
      end
    end

    // R8: a locked register keeps its value
    p_perm_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock[g] |=> $stable(perm_q[g]));
  end

  // R6: at most one register targeted per write
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: rtl/ppr_field_decode.sv
module ppr_field_decode
  import ppr_pkg::*;
#(
  parameter int PERM_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PERM_W-1:0] perm_word,
  input  logic              enable,
  input  logic              lvl_kernel,
  input  logic              mode_guarded,
  input  logic [1:0]        ap,
  input  logic              uxn,
  input  logic              pxn,
  output rights_t           rights
);

  localparam logic [FIELD_W-1:0] F_NORM_NONE = 4'b0111;
  localparam logic [FIELD_W-1:0] F_NORM_XO   = 4'b1001;

  logic [IDX_W-1:0]   idx;
  logic [FIELD_W-1:0] field;
  rights_t            remap_r, legacy_r, norm_r;

  assign idx   = {ap[1], ap[0], uxn, pxn};
  assign field = perm_word[idx*FIELD_W +: FIELD_W];

  always_comb begin
    if (field == F_NORM_NONE)    norm_r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
    else if (field == F_NORM_XO) norm_r = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
    else                         norm_r = code_to_rights(field[CODE_W-1:0]);
    remap_r = mode_guarded ? code_to_rights(field[FIELD_W-1:CODE_W]) : norm_r;
  end

  always_comb begin
    if (mode_guarded) begin
      legacy_r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
    end else if (lvl_kernel) begin
      legacy_r = '{rd: 1'b1, wr: !ap[1], ex: !pxn};
    end else begin
      legacy_r = '{rd: ap[0], wr: ap[0] && !ap[1], ex: ap[0] && !uxn};
    end
  end

  assign rights = enable ? remap_r : legacy_r;

  // R3: no write right without read right
  p_wr_needs_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rights.wr |-> rights.rd);
  // R11: guarded mode closed while disabled
  p_guard_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && mode_guarded) |-> (rights == '0));

endmodule

// File: rtl/ppr_remap_unit.sv
module ppr_remap_unit
  import ppr_pkg::*;
#(
  parameter int DATA_W        = 64,
  parameter int EN_BIT        = 0,
  parameter int LOCK_CFG_BIT  = 1,
  parameter int LOCK_USER_BIT = 4,
  parameter int LOCK_KERN_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lvl_kernel,
  input  logic              mode_guarded,
  input  logic [1:0]        ap,
  input  logic              uxn,
  input  logic              pxn,
  output logic              can_read,
  output logic              can_write,
  output logic              can_exec
);

  localparam int NUM_FIELDS = 1 << IDX_W;
  localparam int PERM_W     = NUM_FIELDS * FIELD_W;
  localparam int LEVELS     = 2;
  localparam int LVL_USER   = 0;
  localparam int LVL_KERN   = 1;

  logic                          cfg_hit;
  logic [LEVELS-1:0]             bank_hit;
  logic                          enable_q, lock_cfg_q, lock_user_q, lock_kern_q;
  logic [LEVELS-1:0][PERM_W-1:0] perm_q;
  logic [PERM_W-1:0]             sel_word;
  rights_t                       rights;

  always_comb begin
    cfg_hit  = 1'b0;
    bank_hit = '0;
    if (wr_en) begin
      case (wsel_e'(wr_sel))
        SEL_CFG:  cfg_hit            = 1'b1;
        SEL_USER: bank_hit[LVL_USER] = 1'b1;
        SEL_KERN: bank_hit[LVL_KERN] = 1'b1;
        default:  ;
      endcase
    end
  end

  ppr_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (cfg_hit),
    .d_enable    (wr_data[EN_BIT]),
    .d_lock_cfg  (wr_data[LOCK_CFG_BIT]),
    .d_lock_user (wr_data[LOCK_USER_BIT]),
    .d_lock_kern (wr_data[LOCK_KERN_BIT]),
    .enable_q    (enable_q),
    .lock_cfg_q  (lock_cfg_q),
    .lock_user_q (lock_user_q),
    .lock_kern_q (lock_kern_q)
  );

  ppr_perm_bank #(.LEVELS(LEVELS), .PERM_W(PERM_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (bank_hit),
    .wr_data (wr_data[PERM_W-1:0]),
    .lock    ({lock_kern_q, lock_user_q}),
    .perm_q  (perm_q)
  );

  assign sel_word = lvl_kernel ? perm_q[LVL_KERN] : perm_q[LVL_USER];

  ppr_field_decode #(.PERM_W(PERM_W)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .perm_word    (sel_word),
    .enable       (enable_q),
    .lvl_kernel   (lvl_kernel),
    .mode_guarded (mode_guarded),
    .ap           (ap),
    .uxn          (uxn),
    .pxn          (pxn),
    .rights       (rights)
  );

  assign can_read  = rights.rd;
  assign can_write = rights.wr;
  assign can_exec  = rights.ex;

  // R6: target 3 leaves all state untouched
  p_sel_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> $stable({perm_q, enable_q, lock_cfg_q, lock_user_q, lock_kern_q}));

endmodule

// File: tb/ppr_remap_unit_tb.sv
module ppr_remap_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = '0;
  logic        lvl_kernel = 1'b0;
  logic        mode_guarded = 1'b0;
  logic [1:0]  ap = 2'd0;
  logic        uxn = 1'b0;
  logic        pxn = 1'b0;
  logic        can_read, can_write, can_exec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ppr_remap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lvl_kernel(lvl_kernel), .mode_guarded(mode_guarded), .ap(ap), .uxn(uxn), .pxn(pxn),
    .can_read(can_read), .can_write(can_write), .can_exec(can_exec)
  );

  // expected {rd,wr,ex} for a remap field
  function automatic logic [2:0] code_exp(input logic [1:0] c);
    case (c)
      2'd1: return 3'b101;
      2'd2: return 3'b100;
      2'd3: return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] field_exp(input logic [3:0] f, input bit g);
    if (g) return code_exp(f[3:2]);
    if (f == 4'd7) return 3'b000;
    if (f == 4'd9) return 3'b001;
    return code_exp(f[1:0]);
  endfunction

  function automatic logic [2:0] legacy_exp(input bit k, input bit g, input logic [3:0] i);
    logic a1, a0, u, p;
    {a1, a0, u, p} = i;
    if (g) return 3'b000;
    if (k) return {1'b1, ~a1, ~p};
    return {a0, a0 & ~a1, a0 & ~u};
  endfunction

  function automatic logic [3:0] user_f(input int i, input int k);
    return 4'((i + k) & 15);
  endfunction

  function automatic logic [3:0] kern_f(input int i, input int k);
    return 4'((i * 7 + k + 3) & 15);
  endfunction

  function automatic logic [63:0] build(input bit kern, input int k);
    logic [63:0] w = '0;
    for (int i = 0; i < 16; i++) w[i*4 +: 4] = kern ? kern_f(i, k) : user_f(i, k);
    return w;
  endfunction

  task automatic do_write(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic look(input string req, input bit k, input bit g, input int i, input logic [2:0] exp);
    lvl_kernel = k; mode_guarded = g; {ap, uxn, pxn} = 4'(i);
    #1;
    n_chk++;
    if ({can_read, can_write, can_exec} !== exp) begin
      n_fail++;
      $display("FAIL %s lvl=%0d guard=%0d idx=%0d actual=%b expected=%b",
               req, k, g, i, {can_read, can_write, can_exec}, exp);
    end
  endtask

  task automatic sweep_legacy(input string req);
    for (int k = 0; k < 2; k++)
      for (int g = 0; g < 2; g++)
        for (int i = 0; i < 16; i++)
          look(req, bit'(k), bit'(g), i, legacy_exp(bit'(k), bit'(g), 4'(i)));
  endtask

  task automatic sweep_remap(input string req, input int ku, input int kk);
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < 16; i++) begin
        look(req, 1'b0, bit'(g), i, field_exp(user_f(i, ku), bit'(g)));
        look(req, 1'b1, bit'(g), i, field_exp(kern_f(i, kk), bit'(g)));
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R10 / R11: reset state gives fallback decode
    sweep_legacy("R1_R10_R11 reset fallback");

    // R2-R5: enable and sweep rotated patterns, all field values both levels
    do_write(2'd0, 64'h1);
    for (int k = 0; k < 16; k++) begin
      do_write(2'd1, build(1'b0, k));
      do_write(2'd2, build(1'b1, k));
      sweep_remap("R2_R3_R4_R5_R6 remap", k, k);
    end

    // R6: target 3 writes nothing
    do_write(2'd3, 64'h0123_4567_89AB_CDEF);
    sweep_remap("R6 no target", 15, 15);

    // R8: lock user register, user write ignored, kernel still writable
    do_write(2'd0, 64'h11);
    do_write(2'd1, build(1'b0, 4));
    do_write(2'd2, build(1'b1, 6));
    sweep_remap("R8 user lock", 15, 6);

    // R9: write config with user-lock bit 0 and kernel-lock 1; user stays locked
    do_write(2'd0, 64'h21);
    do_write(2'd1, build(1'b0, 9));
    do_write(2'd2, build(1'b1, 11));
    sweep_remap("R8_R9 both locked", 15, 6);

    // R7: lock configuration while disabling, then try to re-enable
    do_write(2'd0, 64'h2);
    sweep_legacy("R10 disabled");
    do_write(2'd0, 64'h1);
    sweep_legacy("R7 config frozen");

    finish_run();
  end

endmodule